// File: doc/BRIEF.md
# Dual Phase/Frequency Detector with Lock Status and Output Selector

This block holds two independent digital phase/frequency detectors for a
two-loop frequency synthesizer. Each channel watches the divided reference
pulse and the divided feedback pulse. It drives pump-up and pump-down
commands to an external charge pump. The first rising edge to arrive opens the
matching pump output. The second edge opens the other output. Both outputs
then stay asserted together for a fixed number of fast-clock cycles before the
channel clears. A perfectly aligned loop therefore still produces a short
pulse on both outputs in every comparison cycle, so there is no dead zone. A
polarity input for each channel swaps the two pump outputs, which serves loops
whose oscillator tunes with a negative slope.

Each channel's lock status is high whenever neither of its pump outputs is
active. A third status is high only when both channels are locked. A
registered selector routes one of eight sources to a shared multi-function
pin: a constant low, one of the three lock statuses, or one of the four raw
divider inputs. Power-down drives that pin low whatever the selection.

Each channel runs a four-state machine: `PFD_IDLE`, `PFD_LEAD_UP`,
`PFD_LEAD_DN` and `PFD_RESET_HOLD`. The transitions are as follows.
- From IDLE, a reference edge alone goes to LEAD_UP.
- From IDLE, a feedback edge alone goes to LEAD_DN.
- From IDLE, both edges in one cycle go straight to RESET_HOLD.
- From LEAD_UP, a feedback edge goes to RESET_HOLD.
- From LEAD_DN, a reference edge goes to RESET_HOLD.
- From RESET_HOLD, the channel returns to IDLE after `RST_DLY` cycles.

Top module: `pfd_dual_lockdet`

## Requirements
- R1: While reset is held and in the first cycle after it is released, all four pump outputs are low, all three lock outputs are high and `mfo_o` is low.
- R2: With polarity 1, a rising edge on a reference input asserts that channel's up output from the next clock edge. The output holds until a feedback edge arrives. Both outputs are then high for `RST_DLY` cycles, after which both go low.
- R3: With polarity 1, a feedback edge that arrives first asserts the down output in the same way. A later reference edge leads to the `RST_DLY`-cycle interval with both outputs high, and then both go low.
- R4: Reference and feedback edges in the same cycle give exactly `RST_DLY` cycles with both outputs high and no cycle with only one of them high.
- R5: Further edges on the leading input while that channel waits for the other input are ignored. Any edges that arrive while both outputs are high are also ignored.
- R6: With polarity 0, the up and down outputs of the channel are swapped, with no change in timing.
- R7: Each lock output is high exactly when neither pump output of its channel is high.
- R8: `lock_both_o` is high exactly when both channel lock outputs are high.
- R9: `mfo_sel_i` selects the source of `mfo_o` as follows: 0 = low, 1 = channel 1 lock, 2 = channel 2 lock, 3 = both locked, 4 = `ref1_i`, 5 = `fb1_i`, 6 = `ref2_i`, 7 = `fb2_i`.
- R10: When `pwr_down_i` is high at a clock edge, `mfo_o` is low after that edge, for every selection.
- R11: The two channels are independent. Inputs, polarity and state of one channel never change the other channel's outputs.
- R12: `mfo_o` is registered. After each clock edge it shows the selected source as it was sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref1_i | input | 1 | Channel 1 reference divider output |
| fb1_i | input | 1 | Channel 1 feedback divider output |
| ref2_i | input | 1 | Channel 2 reference divider output |
| fb2_i | input | 1 | Channel 2 feedback divider output |
| pol1_i | input | 1 | Channel 1 polarity (1 = positive tuning slope) |
| pol2_i | input | 1 | Channel 2 polarity (1 = positive tuning slope) |
| mfo_sel_i | input | 3 | Multi-function output source select |
| pwr_down_i | input | 1 | Power-down, forces `mfo_o` low |
| up1_o | output | 1 | Channel 1 pump-up command |
| dn1_o | output | 1 | Channel 1 pump-down command |
| up2_o | output | 1 | Channel 2 pump-up command |
| dn2_o | output | 1 | Channel 2 pump-down command |
| lock1_o | output | 1 | Channel 1 lock status |
| lock2_o | output | 1 | Channel 2 lock status |
| lock_both_o | output | 1 | High when both channels are locked |
| mfo_o | output | 1 | Multi-function output pin |

## Verification
Directed patterns cover a leading reference, a leading feedback, aligned edges
and extra edges on the leading input. Together they separate the two
one-sided paths from the both-high hold and show that surplus edges are
dropped. Every selector code is applied under power-down and with power-down
off, using distinct input levels, so a swapped or misdecoded source shows up.
Long random stretches then vary edge timing, polarity and selection on both
channels at once. These stretches catch cross-talk between the channels and
polarity swaps applied at the wrong point.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef enum logic [1:0] {
        PFD_IDLE       = 2'd0,
        PFD_LEAD_UP    = 2'd1,
        PFD_LEAD_DN    = 2'd2,
        PFD_RESET_HOLD = 2'd3
    } pfd_state_e;

    typedef enum logic [2:0] {
        MFO_LOW       = 3'd0,
        MFO_LOCK1     = 3'd1,
        MFO_LOCK2     = 3'd2,
        MFO_LOCK_BOTH = 3'd3,
        MFO_REF1      = 3'd4,
        MFO_FB1       = 3'd5,
        MFO_REF2      = 3'd6,
        MFO_FB2       = 3'd7
    } mfo_sel_e;

endpackage

// File: rtl/pfd_edge_det.sv
module pfd_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o
);
    logic sig_q;

    always_ff @(posedge clk) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig_i;
    end

    assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/pfd_channel.sv
module pfd_channel
    import pfd_pkg::*;
#(
    parameter int RST_DLY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_rise_i,
    input  logic fb_rise_i,
    input  logic pol_i,
    output logic up_o,
    output logic dn_o,
    output logic lock_o
);
    localparam int CW = (RST_DLY < 2) ? 1 : $clog2(RST_DLY + 1);
    localparam logic [CW-1:0] HOLD_LAST = CW'(RST_DLY - 1);

    pfd_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic raw_up, raw_dn;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PFD_IDLE: begin
                if (ref_rise_i && fb_rise_i) state_d = PFD_RESET_HOLD;
                else if (ref_rise_i)         state_d = PFD_LEAD_UP;
                else if (fb_rise_i)          state_d = PFD_LEAD_DN;
            end
            PFD_LEAD_UP:    if (fb_rise_i)  state_d = PFD_RESET_HOLD;
            PFD_LEAD_DN:    if (ref_rise_i) state_d = PFD_RESET_HOLD;
            PFD_RESET_HOLD: if (cnt_q == HOLD_LAST) state_d = PFD_IDLE;
            default:        state_d = PFD_IDLE;
        endcase
    end

    // state register with the hold-interval counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PFD_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == PFD_RESET_HOLD && state_d == PFD_RESET_HOLD)
                cnt_q <= cnt_q + 1'b1;
            else
                cnt_q <= '0;
        end
    end

    // output decode
    always_comb begin
        raw_up = 1'b0;
        raw_dn = 1'b0;
        unique case (state_q)
            PFD_IDLE:       ;
            PFD_LEAD_UP:    raw_up = 1'b1;
            PFD_LEAD_DN:    raw_dn = 1'b1;
            PFD_RESET_HOLD: begin
                raw_up = 1'b1;
                raw_dn = 1'b1;
            end
            default:        ;
        endcase
    end

    assign up_o   = pol_i ? raw_up : raw_dn;
    assign dn_o   = pol_i ? raw_dn : raw_up;
    assign lock_o = ~(raw_up | raw_dn);
endmodule

// File: rtl/pfd_mfo_mux.sv
module pfd_mfo_mux
    import pfd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel_i,
    input  logic       pwr_down_i,
    input  logic       lock1_i,
    input  logic       lock2_i,
    input  logic       ref1_i,
    input  logic       fb1_i,
    input  logic       ref2_i,
    input  logic       fb2_i,
    output logic       mfo_o
);
    mfo_sel_e sel;
    logic     pick;

    assign sel = mfo_sel_e'(sel_i);

    always_comb begin
        pick = 1'b0;
        unique case (sel)
            MFO_LOW:       pick = 1'b0;
            MFO_LOCK1:     pick = lock1_i;
            MFO_LOCK2:     pick = lock2_i;
            MFO_LOCK_BOTH: pick = lock1_i & lock2_i;
            MFO_REF1:      pick = ref1_i;
            MFO_FB1:       pick = fb1_i;
            MFO_REF2:      pick = ref2_i;
            MFO_FB2:       pick = fb2_i;
            default:       pick = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)          mfo_o <= 1'b0;
        else if (pwr_down_i) mfo_o <= 1'b0;
        else                 mfo_o <= pick;
    end
endmodule

// File: rtl/pfd_dual_lockdet.sv
module pfd_dual_lockdet #(
    parameter int RST_DLY = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref1_i,
    input  logic       fb1_i,
    input  logic       ref2_i,
    input  logic       fb2_i,
    input  logic       pol1_i,
    input  logic       pol2_i,
    input  logic [2:0] mfo_sel_i,
    input  logic       pwr_down_i,
    output logic       up1_o,
    output logic       dn1_o,
    output logic       up2_o,
    output logic       dn2_o,
    output logic       lock1_o,
    output logic       lock2_o,
    output logic       lock_both_o,
    output logic       mfo_o
);
    localparam int NCH = 2;

    logic [NCH-1:0] ref_v, fb_v, pol_v, ref_rise, fb_rise, up_v, dn_v, lock_v;

    assign ref_v = {ref2_i, ref1_i};
    assign fb_v  = {fb2_i, fb1_i};
    assign pol_v = {pol2_i, pol1_i};

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pfd_edge_det ref_ed_i (
            .clk(clk), .rst_n(rst_n), .sig_i(ref_v[c]), .rise_o(ref_rise[c])
        );
        pfd_edge_det fb_ed_i (
            .clk(clk), .rst_n(rst_n), .sig_i(fb_v[c]), .rise_o(fb_rise[c])
        );
        pfd_channel #(.RST_DLY(RST_DLY)) ch_i (
            .clk(clk), .rst_n(rst_n),
            .ref_rise_i(ref_rise[c]), .fb_rise_i(fb_rise[c]),
            .pol_i(pol_v[c]),
            .up_o(up_v[c]), .dn_o(dn_v[c]), .lock_o(lock_v[c])
        );
    end

    assign up1_o       = up_v[0];
    assign dn1_o       = dn_v[0];
    assign up2_o       = up_v[1];
    assign dn2_o       = dn_v[1];
    assign lock1_o     = lock_v[0];
    assign lock2_o     = lock_v[1];
    assign lock_both_o = &lock_v;

    pfd_mfo_mux mux_i (
        .clk(clk), .rst_n(rst_n),
        .sel_i(mfo_sel_i), .pwr_down_i(pwr_down_i),
        .lock1_i(lock_v[0]), .lock2_i(lock_v[1]),
        .ref1_i(ref1_i), .fb1_i(fb1_i), .ref2_i(ref2_i), .fb2_i(fb2_i),
        .mfo_o(mfo_o)
    );
endmodule

// File: rtl/pfd_dual_chk.sv
module pfd_dual_chk #(
    parameter int RST_DLY = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ref1_i,
    input logic       fb1_i,
    input logic       ref2_i,
    input logic       fb2_i,
    input logic       pol1_i,
    input logic       pol2_i,
    input logic [2:0] mfo_sel_i,
    input logic       pwr_down_i,
    input logic       up1_o,
    input logic       dn1_o,
    input logic       up2_o,
    input logic       dn2_o,
    input logic       lock1_o,
    input logic       lock2_o,
    input logic       lock_both_o,
    input logic       mfo_o
);
    logic [7:0] both1_cnt, both2_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            both1_cnt <= '0;
            both2_cnt <= '0;
        end else begin
            both1_cnt <= (up1_o && dn1_o) ? ((both1_cnt == 8'hFF) ? both1_cnt : both1_cnt + 8'd1) : 8'd0;
            both2_cnt <= (up2_o && dn2_o) ? ((both2_cnt == 8'hFF) ? both2_cnt : both2_cnt + 8'd1) : 8'd0;
        end
    end

    // R4: both pump outputs never stay high longer than the hold interval
    p_hold_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        32'(both1_cnt) <= RST_DLY && 32'(both2_cnt) <= RST_DLY);

    // R7: lock tracks pump inactivity
    p_lock_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lock1_o == !(up1_o || dn1_o)) && (lock2_o == !(up2_o || dn2_o)));

    // R8: combined lock
    p_lock_both_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lock_both_o == (lock1_o && lock2_o));

    // R10: power-down forces the pin low
    p_pd_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down_i |=> !mfo_o);

    // R9: code 0 selects constant low
    p_sel_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mfo_sel_i == 3'd0) |=> !mfo_o);

    // R12: code 4 passes the sampled channel 1 reference
    p_sel_ref1_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mfo_sel_i == 3'd4 && !pwr_down_i) |=> (mfo_o == $past(ref1_i)));
endmodule

bind pfd_dual_lockdet pfd_dual_chk #(.RST_DLY(RST_DLY)) chk_i (.*);

// File: tb/pfd_dual_lockdet_tb_top.sv
module pfd_dual_lockdet_tb_top;
    localparam int RST_DLY = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref1_i = 0, fb1_i = 0, ref2_i = 0, fb2_i = 0;
    logic pol1_i = 1, pol2_i = 1;
    logic [2:0] mfo_sel_i = 3'd0;
    logic pwr_down_i = 0;
    logic up1_o, dn1_o, up2_o, dn2_o, lock1_o, lock2_o, lock_both_o, mfo_o;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pfd_dual_lockdet #(.RST_DLY(RST_DLY)) dut_i (.*);

    // reference model state: 0 idle, 1 up lead, 2 dn lead, 3 hold
    int   m_st[2];
    int   m_cnt[2];
    logic m_pr[2], m_pf[2];
    logic m_pol[2];
    logic m_mfo;

    function automatic logic f_rup(int st);  return st == 1 || st == 3; endfunction
    function automatic logic f_rdn(int st);  return st == 2 || st == 3; endfunction

    function automatic logic f_mux(logic [2:0] s, logic l1, logic l2,
                                   logic r1, logic f1, logic r2, logic f2);
        case (s)
            3'd0: return 1'b0;
            3'd1: return l1;
            3'd2: return l2;
            3'd3: return l1 & l2;
            3'd4: return r1;
            3'd5: return f1;
            3'd6: return r2;
            default: return f2;
        endcase
    endfunction

    task automatic chk(string req, string name, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, name, act, exp, $time);
        end
    endtask

    task automatic check_all();
        logic eu[2], ed[2], el[2];
        for (int c = 0; c < 2; c++) begin
            eu[c] = m_pol[c] ? f_rup(m_st[c]) : f_rdn(m_st[c]);
            ed[c] = m_pol[c] ? f_rdn(m_st[c]) : f_rup(m_st[c]);
            el[c] = !(f_rup(m_st[c]) || f_rdn(m_st[c]));
        end
        chk("R2 R3 R4 R5 R6", "up1", up1_o, eu[0]);
        chk("R2 R3 R4 R5 R6", "dn1", dn1_o, ed[0]);
        chk("R11", "up2", up2_o, eu[1]);
        chk("R11", "dn2", dn2_o, ed[1]);
        chk("R7", "lock1", lock1_o, el[0]);
        chk("R7", "lock2", lock2_o, el[1]);
        chk("R8", "lock_both", lock_both_o, el[0] & el[1]);
        chk("R9 R10 R12", "mfo", mfo_o, m_mfo);
    endtask

    task automatic model_ch(int c, logic r, logic f);
        logic re, fe;
        re = r & ~m_pr[c];
        fe = f & ~m_pf[c];
        m_pr[c] = r;
        m_pf[c] = f;
        case (m_st[c])
            0: begin
                if (re && fe) m_st[c] = 3;
                else if (re) m_st[c] = 1;
                else if (fe) m_st[c] = 2;
                m_cnt[c] = 0;
            end
            1: if (fe) begin m_st[c] = 3; m_cnt[c] = 0; end
            2: if (re) begin m_st[c] = 3; m_cnt[c] = 0; end
            default: begin
                if (m_cnt[c] == RST_DLY - 1) begin m_st[c] = 0; m_cnt[c] = 0; end
                else m_cnt[c]++;
            end
        endcase
    endtask

    task automatic step(logic r1, logic f1, logic r2, logic f2,
                        logic p1, logic p2, logic [2:0] s, logic pd);
        logic l1, l2;
        @(negedge clk);
        check_all();
        l1 = !(f_rup(m_st[0]) || f_rdn(m_st[0]));
        l2 = !(f_rup(m_st[1]) || f_rdn(m_st[1]));
        ref1_i = r1; fb1_i = f1; ref2_i = r2; fb2_i = f2;
        pol1_i = p1; pol2_i = p2; mfo_sel_i = s; pwr_down_i = pd;
        m_pol[0] = p1; m_pol[1] = p2;
        m_mfo = pd ? 1'b0 : f_mux(s, l1, l2, r1, f1, r2, f2);
        model_ch(0, r1, f1);
        model_ch(1, r2, f2);
    endtask

    // single-channel directed helpers, channel 2 idle
    task automatic idle1(int n, logic p1);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, p1, 1, 3'd1, 0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int c = 0; c < 2; c++) begin
            m_st[c] = 0; m_cnt[c] = 0; m_pr[c] = 0; m_pf[c] = 0; m_pol[c] = 1;
        end
        m_mfo = 0;
        repeat (3) @(negedge clk);
        // R1: reset state while held
        chk("R1", "up1", up1_o, 0);  chk("R1", "dn1", dn1_o, 0);
        chk("R1", "lock1", lock1_o, 1); chk("R1", "lock_both", lock_both_o, 1);
        chk("R1", "mfo", mfo_o, 0);
        rst_n = 1;
        @(posedge clk);

        // R2: reference leads, extra ref edges ignored (R5)
        step(1, 0, 0, 0, 1, 1, 3'd1, 0);
        step(0, 0, 0, 0, 1, 1, 3'd1, 0);
        step(1, 0, 0, 0, 1, 1, 3'd1, 0);
        step(0, 0, 0, 0, 1, 1, 3'd1, 0);
        step(0, 1, 0, 0, 1, 1, 3'd1, 0);
        idle1(6, 1);
        // R3: feedback leads
        step(0, 1, 0, 0, 1, 1, 3'd3, 0);
        step(0, 0, 0, 0, 1, 1, 3'd3, 0);
        step(1, 0, 0, 0, 1, 1, 3'd3, 0);
        idle1(6, 1);
        // R4: aligned edges, edge during hold ignored (R5)
        step(1, 1, 0, 0, 1, 1, 3'd1, 0);
        step(0, 0, 0, 0, 1, 1, 3'd1, 0);
        step(1, 0, 0, 0, 1, 1, 3'd1, 0);
        idle1(6, 1);
        // R6: polarity 0 swaps outputs
        step(1, 0, 0, 0, 0, 1, 3'd1, 0);
        step(0, 0, 0, 0, 0, 1, 3'd1, 0);
        step(0, 1, 0, 0, 0, 1, 3'd1, 0);
        idle1(6, 0);
        // R9 R10: every selector code with and without power-down
        for (int pd = 0; pd < 2; pd++) begin
            for (int s = 0; s < 8; s++) begin
                step(s[0], s[1], ~s[0], s[2], 1, 1, 3'(s), pd[0]);
                step(~s[0], ~s[1], s[0], ~s[2], 1, 1, 3'(s), pd[0]);
                step(0, 0, 0, 0, 1, 1, 3'(s), pd[0]);
                for (int k = 0; k < 4; k++) step(0, 0, 0, 0, 1, 1, 3'(s), pd[0]);
            end
        end
        // R11 R12: random stimulus on both channels
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0] & r[1], r[2] & r[3], r[4] & r[5], r[6] & r[7],
                 (r[15:8] != 0), (r[23:16] != 0),
                 3'(r[26:24]), (r[31:28] == 0));
        end
        step(0, 0, 0, 0, 1, 1, 3'd0, 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule